// File: doc/BRIEF.md
# Bit-Serial RTC Register Sequencer

This block lets a fast host domain read and write the 32-bit registers of a slow always-on real-time-clock domain. The link between them has three wires: an enable, a serial clock and a serial data-in line. Two signals come back: a serial data-out line and a link-ready flag. The host raises a one-cycle request carrying a direction, a 3-bit register address and, for writes, a 32-bit word. The block then does the whole exchange without further help from the host. It brings the link up, shifts the frame, sends the direction bit, and for reads collects the returned word. When it finishes it reports one response pulse with an error flag and the read data.

Every serial clock level is timed by a programmable half-period counted in system clock cycles. Bring-up waits for the ready flag and uses two levels of retry:

- If ready does not arrive within a poll window, the block pulses a ready-reset request, waits a recovery delay and polls again.
- If several such attempts fail, the whole bring-up is repeated.
- If repeated bring-ups fail, the block asks an external serializer to write a fixed 16-bit recovery value into a static register.
- After a bounded number of recovery rounds it gives up and reports an error.

A request that arrives while a transfer is in flight is refused with a one-cycle reject pulse.

Top module: `rtc_serial_master`

## Requirements
- R1: After a synchronous reset, busy, rsp_valid, req_reject, link_sen, link_sclk, link_sdi, rdy_reset and static_start are all 0.
- R2: A write shifts a 35-bit frame with link_sen=1: first the 32 data bits (bit 31 first), then the 3 address bits (bit 2 first). Each bit is one link_sclk pulse. link_sdi is valid at least HALF_CYC cycles before the rising edge and does not change while link_sclk is high. link_sclk stays high for exactly HALF_CYC cycles.
- R3: After the frame comes a mode pulse with link_sen=0. During it link_sdi is 1 for a write and 0 for a read. link_sdi is 0 once the mode pulse ends.
- R4: A read shifts the 3 address bits (bit 2 first) with link_sen=1, then the mode pulse, then 32 more pulses with link_sen=0 and link_sdi=0. link_sdo is sampled after each of those 32 pulses, with the first sample becoming bit 31 of rsp_rdata. The response then has rsp_err=0.
- R5: Bring-up holds link_sen, link_sclk and link_sdi low until link_ready is seen. link_sen then rises and the frame starts.
- R6: If link_ready stays low for POLL_LIMIT cycles, a one-cycle rdy_reset pulse is issued, RST_CYC cycles pass, and polling restarts. Once RETRIES pulses have been issued, the next timeout fails that bring-up attempt without issuing another pulse.
- R7: A failed bring-up is retried after RST_CYC cycles. After RETRIES+1 consecutive failed attempts, the block raises static_start for one cycle with static_val=STAT_INIT (0x180A by default). It waits for static_busy to fall and then starts a new round of attempts.
- R8: When the round that follows the RETRIES-th recovery write also fails, the block returns rsp_valid with rsp_err=1. At that point all three link outputs are low. Reaching this point takes 16 attempts, 48 rdy_reset pulses and 3 static_start pulses with the default retry count.
- R9: A request that arrives while busy is 1 produces req_reject=1 in the following cycle. The transfer in flight continues unchanged.
- R10: rsp_valid lasts exactly one cycle, and busy is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address in the RTC domain |
| req_wdata | input | DATA_W | Word to write |
| busy | output | 1 | A transfer is in progress |
| req_reject | output | 1 | Previous cycle's request was refused |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Link could not be brought up |
| rsp_rdata | output | DATA_W | Word returned by a read |
| link_sen | output | 1 | Serial enable |
| link_sclk | output | 1 | Serial clock |
| link_sdi | output | 1 | Serial data toward the RTC domain |
| link_sdo | input | 1 | Serial data from the RTC domain |
| link_ready | input | 1 | RTC side ready flag |
| rdy_reset | output | 1 | One-cycle ready-reset request |
| static_val | output | STAT_W | Value for the static register recovery write |
| static_start | output | 1 | One-cycle start for the recovery serializer |
| static_busy | input | 1 | Recovery serializer is still working |

## Verification
The hardest state to reach from the ports is the end of the nested retry ladder. It takes sixteen failed bring-ups spread over four rounds, three recovery writes, and the return to idle with an error. The bench reaches it by shrinking the poll window and recovery delay through parameters and holding link_ready low for the whole transfer, while a small model of the serializer answers each start with a few cycles of busy. The bench then counts the reset pulses and recovery writes it observed. A second run releases link_ready only after the first recovery write. This checks that the round counter resumes cleanly and that the transfer that follows still completes without error.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT,
    ST_POLL,
    ST_RRST,
    ST_GAP,
    ST_SGO,
    ST_SHOLD,
    ST_SWAIT,
    ST_SHIFT,
    ST_MODE,
    ST_RECV
  } seq_state_t;

endpackage

// File: rtl/rtc_wait_timer.sv
module rtc_wait_timer #(
  parameter int DLY = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int TW = $clog2(DLY + 1);

  logic          run;
  logic [TW-1:0] cnt;

  assign expired = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      run <= 1'b1;
      cnt <= TW'(DLY - 1);
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_sclk_pulser.sv
module rtc_sclk_pulser #(
  parameter int HALF_CYC = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic sclk,
  output logic done
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic          run;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      cnt  <= '0;
      sclk <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (fire) begin
          run <= 1'b1;
          cnt <= CW'(HALF_CYC - 1);
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (!sclk) begin
        sclk <= 1'b1;
        cnt  <= CW'(HALF_CYC - 1);
      end else begin
        sclk <= 1'b0;
        run  <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_serial_master.sv
module rtc_serial_master
  import rtc_ser_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32,
  parameter int HALF_CYC   = 625,
  parameter int RST_CYC    = 12500,
  parameter int POLL_LIMIT = 40000,
  parameter int RETRIES    = 3,
  parameter int STAT_W     = 16,
  parameter logic [STAT_W-1:0] STAT_INIT = 16'h180A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              req_reject,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              link_sen,
  output logic              link_sclk,
  output logic              link_sdi,
  input  logic              link_sdo,
  input  logic              link_ready,
  output logic              rdy_reset,
  output logic [STAT_W-1:0] static_val,
  output logic              static_start,
  input  logic              static_busy
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int BCW     = $clog2(FRAME_W + 1);
  localparam int PCW     = $clog2(POLL_LIMIT + 1);
  localparam int RCW     = $clog2(RETRIES + 1);

  seq_state_t         state;
  logic               op_wr;
  logic [FRAME_W-1:0] sr;
  logic [BCW-1:0]     bits_left;
  logic [DATA_W-1:0]  rx;
  logic [PCW-1:0]     poll_cnt;
  logic [RCW-1:0]     rdy_try;
  logic [RCW-1:0]     init_cnt;
  logic [RCW-1:0]     round_cnt;
  logic               fire;
  logic               tload;
  logic               pulse_done;
  logic               t_done;

  rtc_sclk_pulser #(.HALF_CYC(HALF_CYC)) pulser_i (
    .clk  (clk),
    .rst  (rst),
    .fire (fire),
    .sclk (link_sclk),
    .done (pulse_done)
  );

  rtc_wait_timer #(.DLY(RST_CYC)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .load    (tload),
    .expired (t_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      op_wr        <= 1'b0;
      sr           <= '0;
      bits_left    <= '0;
      rx           <= '0;
      poll_cnt     <= '0;
      rdy_try      <= '0;
      init_cnt     <= '0;
      round_cnt    <= '0;
      fire         <= 1'b0;
      tload        <= 1'b0;
      busy         <= 1'b0;
      req_reject   <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_rdata    <= '0;
      link_sen     <= 1'b0;
      link_sdi     <= 1'b0;
      rdy_reset    <= 1'b0;
      static_val   <= '0;
      static_start <= 1'b0;
    end else begin
      fire         <= 1'b0;
      tload        <= 1'b0;
      rsp_valid    <= 1'b0;
      req_reject   <= 1'b0;
      rdy_reset    <= 1'b0;
      static_start <= 1'b0;
      if (req_valid && state != ST_IDLE) req_reject <= 1'b1;

      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            busy      <= 1'b1;
            op_wr     <= req_write;
            sr        <= req_write ? {req_wdata, req_addr} : {req_addr, {DATA_W{1'b0}}};
            bits_left <= req_write ? BCW'(FRAME_W) : BCW'(ADDR_W);
            init_cnt  <= '0;
            round_cnt <= '0;
            state     <= ST_INIT;
          end
        end
        ST_INIT: begin
          link_sen <= 1'b0;
          link_sdi <= 1'b0;
          poll_cnt <= '0;
          rdy_try  <= '0;
          state    <= ST_POLL;
        end
        ST_POLL: begin
          if (link_ready) begin
            link_sen <= 1'b1;
            link_sdi <= sr[FRAME_W-1];
            fire     <= 1'b1;
            state    <= ST_SHIFT;
          end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
            poll_cnt <= '0;
            if (rdy_try != RCW'(RETRIES)) begin
              rdy_reset <= 1'b1;
              rdy_try   <= rdy_try + 1'b1;
              tload     <= 1'b1;
              state     <= ST_RRST;
            end else if (init_cnt != RCW'(RETRIES)) begin
              init_cnt <= init_cnt + 1'b1;
              tload    <= 1'b1;
              state    <= ST_GAP;
            end else if (round_cnt != RCW'(RETRIES)) begin
              init_cnt     <= '0;
              round_cnt    <= round_cnt + 1'b1;
              static_val   <= STAT_INIT;
              static_start <= 1'b1;
              state        <= ST_SGO;
            end else begin
              busy      <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
              state     <= ST_IDLE;
            end
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        ST_RRST: if (t_done) state <= ST_POLL;
        ST_GAP:  if (t_done) state <= ST_INIT;
        ST_SGO:   state <= ST_SHOLD;
        ST_SHOLD: state <= ST_SWAIT;
        ST_SWAIT: begin
          if (!static_busy) begin
            tload <= 1'b1;
            state <= ST_GAP;
          end
        end
        ST_SHIFT: begin
          if (pulse_done) begin
            fire <= 1'b1;
            if (bits_left == BCW'(1)) begin
              link_sen <= 1'b0;
              link_sdi <= op_wr;
              state    <= ST_MODE;
            end else begin
              sr        <= sr << 1;
              link_sdi  <= sr[FRAME_W-2];
              bits_left <= bits_left - 1'b1;
            end
          end
        end
        ST_MODE: begin
          if (pulse_done) begin
            link_sdi <= 1'b0;
            if (op_wr) begin
              busy      <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              state     <= ST_IDLE;
            end else begin
              bits_left <= BCW'(DATA_W);
              fire      <= 1'b1;
              state     <= ST_RECV;
            end
          end
        end
        ST_RECV: begin
          if (pulse_done) begin
            rx <= {rx[DATA_W-2:0], link_sdo};
            if (bits_left == BCW'(1)) begin
              busy      <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              rsp_rdata <= {rx[DATA_W-2:0], link_sdo};
              state     <= ST_IDLE;
            end else begin
              bits_left <= bits_left - 1'b1;
              fire      <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc_serial_master_chk.sv
module rtc_serial_master_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic req_reject,
  input logic rsp_valid,
  input logic link_sen,
  input logic link_sclk,
  input logic link_sdi,
  input logic rdy_reset,
  input logic static_start
);
  // R10
  rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R10
  rsp_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  // R2
  sdi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    link_sclk |=> (!link_sclk || $stable(link_sdi)));

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !link_sclk);

  // R9
  reject_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_reject |-> $past(busy));

  // R6
  rrst_single_chk: assert property (@(posedge clk) disable iff (rst)
    rdy_reset |=> !rdy_reset);

  // R7
  sstart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    static_start |-> (busy && !link_sen && !link_sclk));

  // R7
  sstart_single_chk: assert property (@(posedge clk) disable iff (rst)
    static_start |=> !static_start);
endmodule

bind rtc_serial_master rtc_serial_master_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .req_reject   (req_reject),
  .rsp_valid    (rsp_valid),
  .link_sen     (link_sen),
  .link_sclk    (link_sclk),
  .link_sdi     (link_sdi),
  .rdy_reset    (rdy_reset),
  .static_start (static_start)
);

// File: tb/rtc_serial_master_tb_top.sv
module rtc_serial_master_tb_top;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int HALF   = 2;
  localparam int RSTC   = 5;
  localparam int POLL   = 6;
  localparam int RETR   = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              busy, req_reject, rsp_valid, rsp_err;
  logic [DATA_W-1:0] rsp_rdata;
  logic              link_sen, link_sclk, link_sdi;
  logic              link_sdo = 1'b0;
  logic              link_ready = 1'b0;
  logic              rdy_reset, static_start;
  logic [15:0]       static_val;
  logic              static_busy = 1'b0;

  int total = 0;
  int bad   = 0;

  logic [1:0]  rise_log [0:511];
  int          n_rise = 0;
  int          n_rrst = 0;
  int          n_sst  = 0;
  int          tim_err = 0;
  int          hold_err = 0;
  int          hi_len = 0;
  int          sb_cnt = 0;
  logic [15:0] last_sval = '0;
  logic        prev_sclk = 1'b0;
  logic        prev_sdi = 1'b0;
  logic        rd_on = 1'b0;
  int          rd_base = 0;
  logic [DATA_W-1:0] rd_word = '0;
  logic              got_err;
  logic [DATA_W-1:0] got_data;

  always #4 clk = ~clk;

  rtc_serial_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_CYC(HALF), .RST_CYC(RSTC),
    .POLL_LIMIT(POLL), .RETRIES(RETR), .STAT_W(16), .STAT_INIT(16'h180A)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .req_reject(req_reject), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .link_sen(link_sen), .link_sclk(link_sclk),
    .link_sdi(link_sdi), .link_sdo(link_sdo), .link_ready(link_ready),
    .rdy_reset(rdy_reset), .static_val(static_val),
    .static_start(static_start), .static_busy(static_busy)
  );

  // Link-side model: logs each rising edge, feeds read bits, emulates the serializer.
  always @(negedge clk) begin
    if (link_sclk && !prev_sclk) begin
      if (n_rise < 512) rise_log[n_rise] = {link_sen, link_sdi};
      if (rd_on && (n_rise - rd_base) >= ADDR_W + 1)
        link_sdo = rd_word[DATA_W - 1 - (n_rise - rd_base - ADDR_W - 1)];
      n_rise++;
    end
    if (link_sclk) begin
      hi_len++;
      if (prev_sclk && link_sdi != prev_sdi) hold_err++;
    end else if (prev_sclk) begin
      if (hi_len != HALF) tim_err++;
      hi_len = 0;
    end
    if (rdy_reset) n_rrst++;
    if (static_start) begin
      n_sst++;
      last_sval   = static_val;
      sb_cnt      = 4;
      static_busy = 1'b1;
    end else if (sb_cnt > 0) begin
      sb_cnt--;
      if (sb_cnt == 0) static_busy = 1'b0;
    end
    prev_sclk = link_sclk;
    prev_sdi  = link_sdi;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_req(input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    bit seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        seen = 1; got_err = rsp_err; got_data = rsp_rdata;
      end
    end
    chk(seen, "R10", "response seen", 32'(seen), 1);
    @(negedge clk);
    // R10: single-cycle response, idle afterwards
    chk(!rsp_valid && !busy, "R10", "rsp one cycle, busy low",
        {30'd0, rsp_valid, busy}, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk({busy, rsp_valid, req_reject, link_sen, link_sclk, link_sdi, rdy_reset,
         static_start} == 8'd0, "R1", "outputs in reset",
        {24'd0, busy, rsp_valid, req_reject, link_sen, link_sclk, link_sdi,
         rdy_reset, static_start}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !link_sen, "R1", "idle after reset", {31'd0, busy}, 0);
  endtask

  task automatic t_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input bit poke);
    int base = n_rise;
    int bad_d = 0, bad_a = 0;
    int te0 = tim_err, he0 = hold_err;
    link_ready = 1'b1;
    send_req(1'b1, a, d);
    if (poke) begin
      repeat (5) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = '1; req_wdata = '1;
      @(negedge clk);
      req_valid = 1'b0;
      // R9: request during a transfer is refused
      chk(req_reject, "R9", "reject pulse", {31'd0, req_reject}, 1);
    end
    wait_rsp();
    chk(!got_err, "R2", "write status", {31'd0, got_err}, 0);
    chk(n_rise - base == DATA_W + ADDR_W + 1, "R2", "write pulse count",
        32'(n_rise - base), DATA_W + ADDR_W + 1);
    for (int i = 0; i < DATA_W; i++)
      if (rise_log[base + i] != {1'b1, d[DATA_W-1-i]}) bad_d++;
    for (int i = 0; i < ADDR_W; i++)
      if (rise_log[base + DATA_W + i] != {1'b1, a[ADDR_W-1-i]}) bad_a++;
    // R2: data first, then address, MSB first, enable high
    chk(bad_d == 0, "R2", "data bits", 32'(bad_d), 0);
    chk(bad_a == 0, "R2", "address bits after data", 32'(bad_a), 0);
    // R3: write mode pulse with enable low and data-in high
    chk(rise_log[base + DATA_W + ADDR_W] == 2'b01, "R3", "write mode bit",
        32'(rise_log[base + DATA_W + ADDR_W]), 1);
    chk(!link_sdi && !link_sen, "R3", "sdi/sen low after mode",
        {30'd0, link_sen, link_sdi}, 0);
    chk(tim_err == te0 && hold_err == he0, "R2", "sclk width and sdi hold",
        32'(tim_err - te0 + hold_err - he0), 0);
  endtask

  task automatic t_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] w);
    int base = n_rise;
    int bad_a = 0, bad_r = 0;
    link_ready = 1'b1;
    rd_word = w; rd_base = base; rd_on = 1'b1;
    send_req(1'b0, a, '0);
    wait_rsp();
    rd_on = 1'b0;
    chk(n_rise - base == ADDR_W + 1 + DATA_W, "R4", "read pulse count",
        32'(n_rise - base), ADDR_W + 1 + DATA_W);
    for (int i = 0; i < ADDR_W; i++)
      if (rise_log[base + i] != {1'b1, a[ADDR_W-1-i]}) bad_a++;
    for (int i = 0; i < DATA_W; i++)
      if (rise_log[base + ADDR_W + 1 + i] != 2'b00) bad_r++;
    chk(bad_a == 0, "R4", "read address bits", 32'(bad_a), 0);
    // R3: read mode pulse has data-in low
    chk(rise_log[base + ADDR_W] == 2'b00, "R3", "read mode bit",
        32'(rise_log[base + ADDR_W]), 0);
    chk(bad_r == 0, "R4", "receive pulses quiet", 32'(bad_r), 0);
    chk(!got_err && got_data == w, "R4", "read data", got_data, w);
  endtask

  task automatic t_ready_late();
    int rr0 = n_rrst;
    link_ready = 1'b0;
    send_req(1'b1, 3'd5, 32'h0F0F_1234);
    repeat (2) @(negedge clk);
    // R5: link held low while waiting for ready
    chk(!link_sen && !link_sclk && !link_sdi, "R5", "link low before ready",
        {29'd0, link_sen, link_sclk, link_sdi}, 0);
    link_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(link_sen, "R5", "enable rises after ready", {31'd0, link_sen}, 1);
    wait_rsp();
    chk(n_rrst == rr0 && !got_err, "R5", "no ready reset needed",
        32'(n_rrst - rr0), 0);
  endtask

  task automatic t_recover();
    int rr0 = n_rrst, ss0 = n_sst;
    bit released = 0;
    link_ready = 1'b0;
    send_req(1'b1, 3'd2, 32'hCAFE_0001);
    for (int i = 0; i < 20000 && !released; i++) begin
      @(negedge clk);
      if (n_sst - ss0 >= 1 && !static_busy) begin
        link_ready = 1'b1; released = 1;
      end
    end
    wait_rsp();
    // R6: three ready resets per failed attempt, four attempts
    chk(n_rrst - rr0 == (RETR * (RETR + 1)), "R6", "ready reset count",
        32'(n_rrst - rr0), RETR * (RETR + 1));
    // R7: one recovery write with the fixed value, then success
    chk(n_sst - ss0 == 1, "R7", "recovery write count", 32'(n_sst - ss0), 1);
    chk(last_sval == 16'h180A, "R7", "recovery value", 32'(last_sval), 32'h180A);
    chk(!got_err, "R7", "transfer after recovery", {31'd0, got_err}, 0);
  endtask

  task automatic t_giveup();
    int rr0 = n_rrst, ss0 = n_sst;
    link_ready = 1'b0;
    send_req(1'b0, 3'd1, '0);
    wait_rsp();
    // R8: error after the last round
    chk(got_err, "R8", "error status", {31'd0, got_err}, 1);
    chk(n_sst - ss0 == RETR, "R8", "recovery writes", 32'(n_sst - ss0), RETR);
    chk(n_rrst - rr0 == RETR * (RETR + 1) * (RETR + 1), "R8", "ready resets",
        32'(n_rrst - rr0), RETR * (RETR + 1) * (RETR + 1));
    chk(!link_sen && !link_sclk && !link_sdi, "R8", "link low on error",
        {29'd0, link_sen, link_sclk, link_sdi}, 0);
  endtask

  initial begin
    t_reset();
    t_write(3'd6, 32'hA5C3_0F81, 1'b0);
    t_write(3'd1, 32'h8000_0001, 1'b1);
    t_read(3'd4, 32'hDEAD_BEEF);
    t_read(3'd7, 32'h0000_0001);
    t_ready_late();
    t_recover();
    t_giveup();
    t_read(3'd3, 32'h8123_4567);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule